// File: doc/BRIEF.md
# Binary-Crossbar Integrate-and-Fire Core

This block is a time-stepped spiking core. A set of input axons reaches a set of output neurons through a one-bit-per-crosspoint connection matrix. Every axon carries a two-bit class. Every neuron holds four signed 9-bit weights, one per class. On each accepted tick strobe the core merges the external axon spikes with the spikes that fall due from its own delay buffer. It then walks the axons one per clock. Every neuron connected to an active axon adds the weight it assigns to that axon's class.

After the walk, each neuron adds its signed leak and compares the result with its threshold. A neuron at or above threshold fires and loads its reset value. A neuron below threshold keeps the potential it reached. The spikes that fire are presented on the output vector. Each firing spike is also scheduled into a 16-slot circular buffer at the slot its delay selects, under the axon the neuron targets, so that it re-enters as an axon input on a later tick.

Configuration goes through a single write port with a kind selector, an index and a data word. The parent drives the tick strobe only while the done flag is high.

Top module: `nc_core`

## Requirements
- R1: After a synchronous active-high reset, done_o is 1, spike_o is all zero, every potential is zero and the delay buffer is empty.
- R2: During a tick, neuron j adds weight w[j][k] for every active axon i with crossbar bit row[i][j] = 1, where k is axon i's 2-bit class. Nothing is added for axons that are inactive or unconnected.
- R3: After integration, the signed leak is added, and the neuron fires when the resulting potential is greater than or equal to its signed threshold. At most one spike is produced per neuron per tick.
- R4: A neuron that fires loads its reset value. A neuron that does not fire keeps the integrated potential including leak.
- R5: Potentials are signed, with width 9 + log2(N_AXON) + 2 bits. Every addition, whether weight or leak, saturates at the most positive or most negative value of that width instead of wrapping.
- R6: A spike fired on tick t by a neuron with delay d (1 to 15) becomes an input on the neuron's target axon on tick t+d. A configured delay of 0 behaves as 1.
- R7: Spikes reaching one axon on the same tick are OR-merged into a single input. This covers several neurons with the same target and delivery tick, and also an external spike on that axon.
- R8: A tick strobe seen while done_o is 1 drops done_o on the next cycle. done_o stays low for N_AXON+2 cycles. spike_o takes the new spike vector in the same cycle that done_o returns to 1, and holds it until the next tick completes.
- R9: A tick strobe seen while done_o is 0 is ignored. It starts no extra tick and changes no result.
- R10: A configuration write with cfg_we = 1 selects its target by cfg_kind. Kind 0 writes crossbar row cfg_addr from cfg_data[N_NEUR-1:0]. Kind 1 writes the class of axon cfg_addr from cfg_data[1:0]. Kind 2 writes neuron cfg_addr's weights, with class k in cfg_data[9k+8:9k]. Kind 3 writes leak in [8:0], delay in [12:9] and target axon in [12+log2(N_AXON):13]. Kind 4 writes threshold in the low potential-width bits and reset value in the next potential-width bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Tick strobe, accepted while done_o is 1 |
| axon_i | input | N_AXON | External axon spikes for the tick |
| cfg_we | input | 1 | Configuration write enable |
| cfg_kind | input | 3 | Configuration target selector |
| cfg_addr | input | max(log2 N_AXON, log2 N_NEUR) | Axon or neuron index |
| cfg_data | input | CW | Configuration data word |
| spike_o | output | N_NEUR | Spikes fired by the last completed tick |
| done_o | output | 1 | Core idle and result valid |

## Verification
The embedded properties watch, on every cycle, that a firing neuron holds its reset value and a non-firing neuron sits below threshold. They also watch that spike_o moves only at the end of a tick, that an idle core stays idle without a strobe, that a strobe during a busy tick does not advance the tick count, and that a consumed buffer slot is cleared. Properties cannot show the weighted sums, saturation, delivery delay and OR-merging. The bench shows them by running directed scenarios and randomised configurations against a behavioural model of potentials and delay slots, comparing busy timing and spike vectors cycle by cycle.

// File: rtl/nc_pkg.sv
package nc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DRAIN, ST_FIRE} nc_state_e;
  localparam logic [2:0] K_ROW  = 3'd0;
  localparam logic [2:0] K_TYPE = 3'd1;
  localparam logic [2:0] K_WGT  = 3'd2;
  localparam logic [2:0] K_MISC = 3'd3;
  localparam logic [2:0] K_THR  = 3'd4;
  localparam int DLY_W = 4;
  localparam int SLOTS = 16;
  localparam int NCLS  = 4;
endpackage

// File: rtl/nc_xbar.sv
module nc_xbar #(
  parameter int N_AXON = 256,
  parameter int N_NEUR = 256,
  parameter int AW     = $clog2(N_AXON)
) (
  input  logic              clk,
  input  logic              wr_row,
  input  logic              wr_cls,
  input  logic [AW-1:0]     wr_addr,
  input  logic [N_NEUR-1:0] wr_bits,
  input  logic [1:0]        wr_c,
  input  logic [AW-1:0]     rd_addr,
  output logic [N_NEUR-1:0] rd_bits,
  output logic [1:0]        rd_c
);
  logic [N_NEUR-1:0] row_mem [N_AXON];
  logic [1:0]        cls_mem [N_AXON];

  always_ff @(posedge clk) begin
    if (wr_row) row_mem[wr_addr] <= wr_bits;
    if (wr_cls) cls_mem[wr_addr] <= wr_c;
    rd_bits <= row_mem[rd_addr];
    rd_c    <= cls_mem[rd_addr];
  end
endmodule

// File: rtl/nc_neuron.sv
module nc_neuron #(
  parameter int WW  = 9,
  parameter int VW  = 19,
  parameter int AW  = 8,
  parameter int CWN = 38
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_wgt,
  input  logic           wr_misc,
  input  logic           wr_thr,
  input  logic [CWN-1:0] cfg_d,
  input  logic           acc_hit,
  input  logic [1:0]     acc_c,
  input  logic           fire_en,
  output logic           fire_c,
  output logic           spk_q,
  output logic [3:0]     dly_q,
  output logic [AW-1:0]  tgt_q
);
  localparam logic signed [VW:0] SMAX = {2'b00, {(VW-1){1'b1}}};
  localparam logic signed [VW:0] SMIN = {2'b11, {(VW-1){1'b0}}};

  logic signed [WW-1:0] wgt [nc_pkg::NCLS];
  logic signed [WW-1:0] leak;
  logic signed [VW-1:0] thr, rstv, pot, lv, wext, lext;

  function automatic logic signed [VW-1:0] sat_add(input logic signed [VW-1:0] a,
                                                   input logic signed [VW-1:0] b);
    logic signed [VW:0] s;
    s = {a[VW-1], a} + {b[VW-1], b};
    if (s > SMAX) return SMAX[VW-1:0];
    else if (s < SMIN) return SMIN[VW-1:0];
    else return s[VW-1:0];
  endfunction

  always_comb begin
    wext   = {{(VW-WW){wgt[acc_c][WW-1]}}, wgt[acc_c]};
    lext   = {{(VW-WW){leak[WW-1]}}, leak};
    lv     = sat_add(pot, lext);
    fire_c = (lv >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < nc_pkg::NCLS; k++) wgt[k] <= '0;
      leak <= '0; thr <= '0; rstv <= '0; pot <= '0;
      spk_q <= 1'b0; dly_q <= '0; tgt_q <= '0;
    end else begin
      if (wr_wgt)
        for (int k = 0; k < nc_pkg::NCLS; k++) wgt[k] <= cfg_d[k*WW +: WW];
      if (wr_misc) begin
        leak  <= cfg_d[WW-1:0];
        dly_q <= cfg_d[WW +: 4];
        tgt_q <= cfg_d[WW+4 +: AW];
      end
      if (wr_thr) begin
        thr  <= cfg_d[VW-1:0];
        rstv <= cfg_d[VW +: VW];
      end
      if (acc_hit) pot <= sat_add(pot, wext);
      if (fire_en) begin
        spk_q <= fire_c;
        pot   <= fire_c ? rstv : lv;
      end
    end
  end

  AST_FIRE_LOADS_RESET: assert property (@(posedge clk) disable iff (rst)
    fire_en |=> (!spk_q || pot == $past(rstv))); // R4
  AST_QUIET_BELOW_THR: assert property (@(posedge clk) disable iff (rst)
    fire_en |=> (spk_q || pot < $past(thr))); // R3
endmodule

// File: rtl/nc_dlybuf.sv
module nc_dlybuf #(
  parameter int N_AXON = 256,
  parameter int N_NEUR = 256,
  parameter int AW     = $clog2(N_AXON)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cons,
  input  logic               put,
  input  logic [3:0]         cnt,
  input  logic [N_NEUR-1:0]  fire_v,
  input  logic [N_NEUR*4-1:0] dly_v,
  input  logic [N_NEUR*AW-1:0] tgt_v,
  output logic [N_AXON-1:0]  due
);
  logic [N_AXON-1:0] slot [nc_pkg::SLOTS];
  logic [3:0]        dst [N_NEUR];

  always_comb begin
    for (int j = 0; j < N_NEUR; j++)
      dst[j] = cnt + ((dly_v[j*4 +: 4] == 4'd0) ? 4'd1 : dly_v[j*4 +: 4]);
    due = slot[cnt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < nc_pkg::SLOTS; s++) slot[s] <= '0;
    end else begin
      if (cons) slot[cnt] <= '0;
      if (put)
        for (int j = 0; j < N_NEUR; j++)
          if (fire_v[j]) slot[dst[j]][tgt_v[j*AW +: AW]] <= 1'b1;
    end
  end

  AST_SLOT_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    cons |=> (slot[$past(cnt)] == '0)); // R6
endmodule

// File: rtl/nc_core.sv
module nc_core import nc_pkg::*; #(
  parameter int N_AXON  = 256,
  parameter int N_NEUR  = 256,
  parameter int WW      = 9,
  localparam int AW     = $clog2(N_AXON),
  localparam int NW     = $clog2(N_NEUR),
  localparam int ADW    = (AW > NW) ? AW : NW,
  localparam int VW     = WW + AW + 2,
  localparam int CWN_A  = (4*WW > 2*VW) ? 4*WW : 2*VW,
  localparam int CWN    = (CWN_A > WW+4+AW) ? CWN_A : WW+4+AW,
  localparam int CW     = (N_NEUR > CWN) ? N_NEUR : CWN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [N_AXON-1:0] axon_i,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [ADW-1:0]    cfg_addr,
  input  logic [CW-1:0]     cfg_data,
  output logic [N_NEUR-1:0] spike_o,
  output logic              done_o
);
  nc_state_e         st;
  logic [AW-1:0]     aidx;
  logic [N_AXON-1:0] act, due;
  logic              act_q, vld_q;
  logic [3:0]        tcnt;
  logic [N_NEUR-1:0] row_q, fire_v;
  logic [1:0]        cls_q;
  logic [N_NEUR*4-1:0]  dly_v;
  logic [N_NEUR*AW-1:0] tgt_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; aidx <= '0; act <= '0; act_q <= 1'b0;
      vld_q <= 1'b0; tcnt <= '0; done_o <= 1'b1;
    end else begin
      vld_q <= (st == ST_SCAN);
      act_q <= act[aidx];
      case (st)
        ST_IDLE: if (tick_i) begin
          act <= axon_i | due; aidx <= '0; st <= ST_SCAN; done_o <= 1'b0;
        end
        ST_SCAN: begin
          aidx <= aidx + 1'b1;
          if (aidx == AW'(N_AXON-1)) st <= ST_DRAIN;
        end
        ST_DRAIN: st <= ST_FIRE;
        default: begin
          st <= ST_IDLE; done_o <= 1'b1; tcnt <= tcnt + 1'b1;
        end
      endcase
    end
  end

  nc_xbar #(.N_AXON(N_AXON), .N_NEUR(N_NEUR), .AW(AW)) u_xbar (
    .clk(clk), .wr_row(cfg_we && cfg_kind == K_ROW), .wr_cls(cfg_we && cfg_kind == K_TYPE),
    .wr_addr(cfg_addr[AW-1:0]), .wr_bits(cfg_data[N_NEUR-1:0]), .wr_c(cfg_data[1:0]),
    .rd_addr(aidx), .rd_bits(row_q), .rd_c(cls_q));

  for (genvar j = 0; j < N_NEUR; j++) begin : g_neur
    logic sel;
    assign sel = cfg_we && (cfg_addr == ADW'(j));
    nc_neuron #(.WW(WW), .VW(VW), .AW(AW), .CWN(CWN)) u_n (
      .clk(clk), .rst(rst),
      .wr_wgt(sel && cfg_kind == K_WGT), .wr_misc(sel && cfg_kind == K_MISC),
      .wr_thr(sel && cfg_kind == K_THR), .cfg_d(cfg_data[CWN-1:0]),
      .acc_hit(vld_q && act_q && row_q[j]), .acc_c(cls_q), .fire_en(st == ST_FIRE),
      .fire_c(fire_v[j]), .spk_q(spike_o[j]), .dly_q(dly_v[j*4 +: 4]),
      .tgt_q(tgt_v[j*AW +: AW]));
  end

  nc_dlybuf #(.N_AXON(N_AXON), .N_NEUR(N_NEUR), .AW(AW)) u_dly (
    .clk(clk), .rst(rst), .cons(st == ST_IDLE && tick_i), .put(st == ST_FIRE),
    .cnt(tcnt), .fire_v(fire_v), .dly_v(dly_v), .tgt_v(tgt_v), .due(due));

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !tick_i) |=> done_o); // R8
  AST_SPIKES_HELD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_FIRE) |=> $stable(spike_o)); // R8
  AST_BUSY_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(tcnt))); // R9
endmodule

// File: tb/nc_core_tb.sv
module nc_core_tb;
  localparam int NA = 8, NN = 8, WW = 9, VW = 14, CW = 36, ADW = 3;
  localparam int VMAX = 8191, VMIN = -8192;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tick_i, cfg_we;
  logic [NA-1:0] axon_i;
  logic [2:0] cfg_kind;
  logic [ADW-1:0] cfg_addr;
  logic [CW-1:0] cfg_data;
  logic [NN-1:0] spike_o;
  logic done_o;

  nc_core #(.N_AXON(NA), .N_NEUR(NN), .WW(WW)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .axon_i(axon_i), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .spike_o(spike_o), .done_o(done_o));

  logic [NN-1:0] m_row [NA];
  int m_cls [NA];
  int m_w [NN][4];
  int m_leak [NN], m_thr [NN], m_rv [NN], m_dly [NN], m_tgt [NN], m_pot [NN];
  logic [NA-1:0] m_buf [16];
  int m_tc;
  logic [NN-1:0] m_spk;
  int nchk = 0, nfail = 0;

  task automatic check(input string tag, input string what, input longint got, input longint exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int sat(input int x);
    if (x > VMAX) return VMAX;
    if (x < VMIN) return VMIN;
    return x;
  endfunction

  task automatic cfg_wr(input logic [2:0] k, input int a, input logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_addr = ADW'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R10: kind 0 row, 1 class, 2 weights, 3 leak/delay/target, 4 threshold/reset
  task automatic set_row(input int a, input logic [NN-1:0] b);
    m_row[a] = b; cfg_wr(3'd0, a, CW'(b));
  endtask
  task automatic set_cls(input int a, input int c);
    m_cls[a] = c; cfg_wr(3'd1, a, CW'(c));
  endtask
  task automatic set_wgt(input int j, input int w0, input int w1, input int w2, input int w3);
    logic [CW-1:0] d;
    m_w[j][0] = w0; m_w[j][1] = w1; m_w[j][2] = w2; m_w[j][3] = w3;
    d = '0;
    d[8:0] = 9'(w0); d[17:9] = 9'(w1); d[26:18] = 9'(w2); d[35:27] = 9'(w3);
    cfg_wr(3'd2, j, d);
  endtask
  task automatic set_misc(input int j, input int lk, input int dl, input int tg);
    logic [CW-1:0] d;
    m_leak[j] = lk; m_dly[j] = dl; m_tgt[j] = tg;
    d = '0; d[8:0] = 9'(lk); d[12:9] = 4'(dl); d[15:13] = 3'(tg);
    cfg_wr(3'd3, j, d);
  endtask
  task automatic set_thr(input int j, input int th, input int rv);
    logic [CW-1:0] d;
    m_thr[j] = th; m_rv[j] = rv;
    d = '0; d[13:0] = 14'(th); d[27:14] = 14'(rv);
    cfg_wr(3'd4, j, d);
  endtask

  task automatic model_tick(input logic [NA-1:0] ax);
    logic [NA-1:0] act;
    logic [NN-1:0] ns;
    int p, d;
    act = ax | m_buf[m_tc];           // R7 OR merge
    m_buf[m_tc] = '0;
    for (int j = 0; j < NN; j++) begin
      p = m_pot[j];
      for (int a = 0; a < NA; a++)
        if (act[a] && m_row[a][j]) p = sat(p + m_w[j][m_cls[a]]);   // R2 R5
      p = sat(p + m_leak[j]);
      ns[j] = (p >= m_thr[j]);                                      // R3
      m_pot[j] = ns[j] ? m_rv[j] : p;                               // R4
    end
    for (int j = 0; j < NN; j++)
      if (ns[j]) begin
        d = (m_dly[j] == 0) ? 1 : m_dly[j];                          // R6
        m_buf[(m_tc + d) % 16][m_tgt[j]] = 1'b1;
      end
    m_tc = (m_tc + 1) % 16;
    m_spk = ns;
  endtask

  task automatic run_tick(input logic [NA-1:0] ax, input string tag, input bit poke);
    logic [NN-1:0] prev;
    prev = m_spk;
    @(negedge clk);
    tick_i = 1'b1; axon_i = ax;
    model_tick(ax);
    @(negedge clk);
    tick_i = 1'b0;
    for (int k = 0; k < NA + 2; k++) begin
      check({tag, " R8"}, "done_o busy", longint'(done_o), 0);
      check({tag, " R8"}, "spike_o held", longint'(spike_o), longint'(prev));
      tick_i = poke && (k == 3);
      axon_i = poke ? NA'($urandom) : ax;
      @(negedge clk);
    end
    tick_i = 1'b0;
    check({tag, " R8"}, "done_o end", longint'(done_o), 1);
    check(tag, "spike_o", longint'(spike_o), longint'(m_spk));
    if (poke) begin
      @(negedge clk);
      check("R9", "done_o after busy strobe", longint'(done_o), 1);
      check("R9", "spike_o after busy strobe", longint'(spike_o), longint'(m_spk));
    end
  endtask

  task automatic clear_all();
    for (int a = 0; a < NA; a++) begin set_row(a, '0); set_cls(a, 0); end
    for (int j = 0; j < NN; j++) begin
      set_wgt(j, 0, 0, 0, 0); set_misc(j, 0, 1, 0); set_thr(j, VMAX, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_i = 1'b0; axon_i = '0; cfg_we = 1'b0;
    cfg_kind = '0; cfg_addr = '0; cfg_data = '0;
    for (int j = 0; j < NN; j++) begin
      m_pot[j] = 0; m_leak[j] = 0; m_thr[j] = 0; m_rv[j] = 0; m_dly[j] = 0; m_tgt[j] = 0;
      for (int k = 0; k < 4; k++) m_w[j][k] = 0;
    end
    for (int s = 0; s < 16; s++) m_buf[s] = '0;
    m_tc = 0; m_spk = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done_o after reset", longint'(done_o), 1);
    check("R1", "spike_o after reset", longint'(spike_o), 0);
    clear_all();
    run_tick('0, "R1 quiet tick", 1'b0);

    // R2 R3: class-selected weights, leak, threshold
    set_cls(0, 1); set_cls(1, 2); set_cls(2, 3);
    set_row(0, 8'h01); set_row(1, 8'h03); set_row(2, 8'h02);
    set_wgt(0, 0, 10, -3, 0); set_misc(0, -1, 1, 7); set_thr(0, 20, 0);
    set_wgt(1, 0, 0, 4, 9);   set_misc(1, 0, 1, 7);  set_thr(1, 13, -5);
    for (int t = 0; t < 6; t++) run_tick(NA'(t + 1), "R2 R3 R4 weighted sum", 1'b0);

    // R6 R7: delay line, target axon, OR merge
    clear_all();
    set_misc(0, 10, 3, 5); set_thr(0, 5, 0);
    set_cls(5, 1); set_row(5, 8'h02); set_wgt(1, 0, 7, 0, 0); set_thr(1, 7, 0);
    set_misc(3, 10, 2, 6); set_thr(3, 5, 0);
    set_misc(4, 10, 2, 6); set_thr(4, 5, 0);
    set_cls(6, 2); set_row(6, 8'h20); set_wgt(5, 0, 0, 5, 0);
    set_misc(5, -5, 1, 0); set_thr(5, 5, 0);
    for (int t = 0; t < 12; t++)
      run_tick((t % 3 == 0) ? 8'h40 : 8'h00, "R6 R7 delay and merge", 1'b0);
    set_misc(0, 10, 0, 5);
    for (int t = 0; t < 5; t++) run_tick('0, "R6 zero delay", 1'b0);

    // R5: saturation at the negative limit, then climb back
    clear_all();
    for (int a = 0; a < NA; a++) set_row(a, 8'h04);
    set_wgt(2, -256, 0, 0, 0);
    for (int t = 0; t < 7; t++) run_tick('1, "R5 saturate", 1'b0);
    set_wgt(2, 255, 0, 0, 0); set_thr(2, 0, 0);
    for (int t = 0; t < 6; t++) run_tick('1, "R5 recover", 1'b0);

    // R9: strobe during busy tick
    run_tick(8'h0F, "R9 busy strobe", 1'b1);

    // randomised configurations
    for (int r = 0; r < 6; r++) begin
      for (int a = 0; a < NA; a++) begin
        set_row(a, NN'($urandom)); set_cls(a, int'($urandom_range(3)));
      end
      for (int j = 0; j < NN; j++) begin
        set_wgt(j, int'($urandom_range(511)) - 256, int'($urandom_range(511)) - 256,
                int'($urandom_range(511)) - 256, int'($urandom_range(511)) - 256);
        set_misc(j, int'($urandom_range(60)) - 10, int'($urandom_range(15)),
                 int'($urandom_range(NA-1)));
        set_thr(j, int'($urandom_range(200)) - 20, int'($urandom_range(40)) - 20);
      end
      for (int t = 0; t < 25; t++)
        run_tick(NA'($urandom), "R2 R3 R4 R6 R7 R10 random", (t % 8) == 7);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule